// File: doc/BRIEF.md
# Global-History Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken by combining two sources: a few low-order bits of the branch address and a shift register that remembers whether each of the most recent branches went taken or not taken. The two are joined into one index that selects a saturating counter in an untagged table. A fetch stage presents a PC and gets a taken/not-taken guess back combinationally in the same cycle. The guess comes with the history value it was made under, which the pipeline carries along with the branch.

When the branch resolves, the pipeline presents the branch PC, the carried history snapshot and the real outcome on the update port. The selected counter moves one step toward the outcome, and the outcome is shifted into the global history. History depth, counter width, the number of address index bits and the alignment of the address field are all parameters. Target addresses, tags and history repair after a squash are left to the surrounding logic.

Top module: `corr_bpred`

## Requirements
- R1: A synchronous reset clears the global history to all zeros and sets every counter to 2^(CTR_W-1)-1, so every PC is predicted not taken right after reset.
- R2: Each accepted update shifts the history left by one and places the outcome in bit 0 (1 = taken, 0 = not taken). `pred_hist` shows the current history.
- R3: The table index is the address field `pc[PC_LSB +: IDX_ADDR_W]` in the upper bits and the HIST_W history bits in the lower bits. The same PC under different history values uses separate counters.
- R4: A taken update adds one to the selected counter and saturates at 2^CTR_W-1.
- R5: A not-taken update subtracts one from the selected counter and saturates at 0.
- R6: `pred_taken` is 1 exactly when the selected counter is at least 2^(CTR_W-1).
- R7: An update selects its counter with the history given on `upd_hist`, not with the live history.
- R8: There are no tags. Two PCs with the same address field share counters, and an update through one changes the prediction for the other.
- R9: When a prediction and an update occur in the same cycle, the prediction and `pred_hist` reflect the state before that update.
- R10: While `upd_valid` is low, neither the history nor any counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pred_pc | input | PC_W | PC of the instruction being fetched |
| pred_taken | output | 1 | Predicted direction for `pred_pc` (1 = taken) |
| pred_hist | output | HIST_W | Global history used for this prediction |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_hist | input | HIST_W | History snapshot taken when the branch was predicted |
| upd_taken | input | 1 | Actual outcome (1 = taken) |

## Verification
The bench builds the block with HIST_W=2, CTR_W=2, IDX_ADDR_W=4, PC_LSB=2 and PC_W=16. With 2-bit counters, a handful of updates drives a counter to either saturation limit and across the taken threshold. The 4-bit address field makes aliasing easy to produce: PCs 0x0010 and 0x0050 share a row. The two history bits give four counters per row, so updates can be steered through a stale history snapshot and the effect can be read back once the live history returns to the same value.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic {
        BR_NOT_TAKEN = 1'b0,
        BR_TAKEN     = 1'b1
    } br_dir_e;

    typedef enum logic [1:0] {
        CTR_HOLD = 2'd0,
        CTR_UP   = 2'd1,
        CTR_DOWN = 2'd2
    } ctr_act_e;

    function automatic ctr_act_e ctr_action(input logic valid, input br_dir_e dir);
        if (!valid)
            return CTR_HOLD;
        return (dir == BR_TAKEN) ? CTR_UP : CTR_DOWN;
    endfunction

    function automatic br_dir_e to_dir(input logic bit_in);
        return bit_in ? BR_TAKEN : BR_NOT_TAKEN;
    endfunction

endpackage

// File: rtl/bp_history_reg.sv
module bp_history_reg
    import bp_pkg::*;
#(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  br_dir_e           shift_in,
    output logic [HIST_W-1:0] hist_q
);

    logic [HIST_W-1:0] hist_d;

    generate
        if (HIST_W == 1) begin : g_single
            always_comb hist_d = shift_in;
        end else begin : g_multi
            always_comb hist_d = {hist_q[HIST_W-2:0], shift_in};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            hist_q <= '0;
        else if (shift_en)
            hist_q <= hist_d;
    end

    assert_shift_lsb_R2: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> hist_q[0] == logic'($past(shift_in)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(hist_q));

    generate
        if (HIST_W > 1) begin : g_age_chk
            assert_shift_age_R2: assert property (@(posedge clk) disable iff (rst)
                shift_en |=> hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]));
        end
    endgenerate

endmodule

// File: rtl/bp_index_gen.sv
module bp_index_gen #(
    parameter int PC_W       = 32,
    parameter int PC_LSB     = 2,
    parameter int IDX_ADDR_W = 8,
    parameter int HIST_W     = 2,
    localparam int IDX_W     = IDX_ADDR_W + HIST_W
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);

    logic [IDX_ADDR_W-1:0] row;

    always_comb begin
        row = pc[PC_LSB +: IDX_ADDR_W];
        idx = {row, hist};
    end

endmodule

// File: rtl/bp_counter_table.sv
module bp_counter_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int CTR_W = 2,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_ctr,
    input  ctr_act_e         wr_act,
    input  logic [IDX_W-1:0] wr_idx
);

    localparam logic [CTR_W-1:0] CTR_MAX  = {CTR_W{1'b1}};
    localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'((2 ** (CTR_W - 1)) - 1);

    logic [CTR_W-1:0] ctr_mem [DEPTH];
    logic [CTR_W-1:0] wr_cur;
    logic [CTR_W-1:0] wr_nxt;

    always_comb begin
        rd_ctr = ctr_mem[rd_idx];
        wr_cur = ctr_mem[wr_idx];
        unique case (wr_act)
            CTR_UP:   wr_nxt = (wr_cur == CTR_MAX) ? wr_cur : wr_cur + CTR_W'(1);
            CTR_DOWN: wr_nxt = (wr_cur == '0)      ? wr_cur : wr_cur - CTR_W'(1);
            default:  wr_nxt = wr_cur;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                ctr_mem[i] <= CTR_INIT;
        end else if (wr_act != CTR_HOLD) begin
            ctr_mem[wr_idx] <= wr_nxt;
        end
    end

    assert_inc_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_act == CTR_UP && wr_cur != CTR_MAX)
        |=> ctr_mem[$past(wr_idx)] == $past(wr_cur) + CTR_W'(1));

    assert_sat_hi_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_act == CTR_UP && wr_cur == CTR_MAX)
        |=> ctr_mem[$past(wr_idx)] == CTR_MAX);

    assert_dec_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_act == CTR_DOWN && wr_cur != '0)
        |=> ctr_mem[$past(wr_idx)] == $past(wr_cur) - CTR_W'(1));

    assert_sat_lo_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_act == CTR_DOWN && wr_cur == '0)
        |=> ctr_mem[$past(wr_idx)] == '0);

endmodule

// File: rtl/corr_bpred.sv
module corr_bpred
    import bp_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int PC_LSB     = 2,
    parameter int IDX_ADDR_W = 8,
    parameter int HIST_W     = 2,
    parameter int CTR_W      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PC_W-1:0]   pred_pc,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_hist,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic [HIST_W-1:0] upd_hist,
    input  logic              upd_taken
);

    localparam int IDX_W = IDX_ADDR_W + HIST_W;

    logic [HIST_W-1:0] ghist;
    logic [IDX_W-1:0]  pred_idx;
    logic [IDX_W-1:0]  upd_idx;
    logic [CTR_W-1:0]  pred_ctr;
    br_dir_e           upd_dir;
    ctr_act_e          upd_act;

    always_comb begin
        upd_dir = to_dir(upd_taken);
        upd_act = ctr_action(upd_valid, upd_dir);
    end

    bp_history_reg #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (upd_valid),
        .shift_in (upd_dir),
        .hist_q   (ghist)
    );

    bp_index_gen #(
        .PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_ADDR_W(IDX_ADDR_W), .HIST_W(HIST_W)
    ) u_pred_idx (
        .pc   (pred_pc),
        .hist (ghist),
        .idx  (pred_idx)
    );

    bp_index_gen #(
        .PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_ADDR_W(IDX_ADDR_W), .HIST_W(HIST_W)
    ) u_upd_idx (
        .pc   (upd_pc),
        .hist (upd_hist),
        .idx  (upd_idx)
    );

    bp_counter_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_table (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (pred_idx),
        .rd_ctr (pred_ctr),
        .wr_act (upd_act),
        .wr_idx (upd_idx)
    );

    always_comb begin
        pred_taken = pred_ctr[CTR_W-1];
        pred_hist  = ghist;
    end

endmodule

// File: tb/corr_bpred_tb_top.sv
module corr_bpred_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PC_W = 16;

    typedef struct packed {
        logic            uv;
        logic [PC_W-1:0] upc;
        logic [1:0]      uh;
        logic            ut;
        logic [PC_W-1:0] ppc;
        logic            ep;
        logic [1:0]      eh;
    } vec_t;

    // Rows: 0x0010 and 0x0050 alias to row 4, 0x0020 is row 8.
    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 16'h0010, 2'd0, 1'b1, 16'h0010, 1'b0, 2'd1},
        '{1'b1, 16'h0010, 2'd0, 1'b1, 16'h0010, 1'b0, 2'd3},
        '{1'b1, 16'h0020, 2'd3, 1'b0, 16'h0010, 1'b0, 2'd2},
        '{1'b1, 16'h0020, 2'd2, 1'b0, 16'h0010, 1'b1, 2'd0},
        '{1'b1, 16'h0050, 2'd0, 1'b0, 16'h0010, 1'b1, 2'd0},
        '{1'b1, 16'h0050, 2'd0, 1'b0, 16'h0010, 1'b0, 2'd0},
        '{1'b1, 16'h0020, 2'd1, 1'b1, 16'h0020, 1'b1, 2'd1},
        '{1'b0, 16'h0020, 2'd1, 1'b0, 16'h0020, 1'b1, 2'd1},
        '{1'b1, 16'h0020, 2'd1, 1'b0, 16'h0020, 1'b0, 2'd2},
        '{1'b1, 16'h0020, 2'd2, 1'b0, 16'h0020, 1'b0, 2'd0},
        '{1'b1, 16'h0020, 2'd2, 1'b1, 16'h0020, 1'b0, 2'd1},
        '{1'b1, 16'h0020, 2'd2, 1'b1, 16'h0020, 1'b0, 2'd3},
        '{1'b1, 16'h0010, 2'd0, 1'b0, 16'h0020, 1'b1, 2'd2}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] pred_pc = '0;
    logic            pred_taken;
    logic [1:0]      pred_hist;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic [1:0]      upd_hist = '0;
    logic            upd_taken = 1'b0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    corr_bpred #(
        .PC_W(PC_W), .PC_LSB(2), .IDX_ADDR_W(4), .HIST_W(2), .CTR_W(2)
    ) dut_i (
        .clk(clk), .rst(rst),
        .pred_pc(pred_pc), .pred_taken(pred_taken), .pred_hist(pred_hist),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_hist(upd_hist), .upd_taken(upd_taken)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic do_update(input logic [PC_W-1:0] pc, input logic [1:0] h, input logic t);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_hist = h; upd_taken = t;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic probe(input logic [PC_W-1:0] pc, input logic ep, input logic [1:0] eh,
                         input string tag);
        pred_pc = pc;
        #1;
        chk(32'(pred_taken), 32'(ep), {tag, " pred_taken"});
        chk(32'(pred_hist), 32'(eh), {tag, " pred_hist"});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        probe(16'h0010, 1'b0, 2'd0, "R1 reset pc10");
        probe(16'h0020, 1'b0, 2'd0, "R1 reset pc20");
        probe(16'h0030, 1'b0, 2'd0, "R1 reset pc30");

        // Vector walk: R2 history, R3 index, R6 threshold, R7 stale history,
        // R8 aliasing, R10 idle, R5 low saturation
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            upd_valid = VECS[v].uv; upd_pc = VECS[v].upc;
            upd_hist = VECS[v].uh; upd_taken = VECS[v].ut;
            @(negedge clk);
            upd_valid = 1'b0;
            probe(VECS[v].ppc, VECS[v].ep, VECS[v].eh, $sformatf("R6/R2 vec%0d", v));
        end

        // R4: upper saturation on row 12, history 0
        do_update(16'h0030, 2'd0, 1'b1);
        do_update(16'h0030, 2'd0, 1'b1);
        do_update(16'h0030, 2'd0, 1'b1);
        do_update(16'h0030, 2'd0, 1'b0);
        do_update(16'h0030, 2'd0, 1'b0);
        probe(16'h0030, 1'b0, 2'd0, "R4 saturate high");

        // R9: same-cycle predict and update to one index
        @(negedge clk);
        pred_pc = 16'h0030;
        upd_valid = 1'b1; upd_pc = 16'h0030; upd_hist = 2'd0; upd_taken = 1'b1;
        #1;
        chk(32'(pred_taken), 32'd0, "R9 pre-update pred");
        chk(32'(pred_hist), 32'd0, "R9 pre-update hist");
        @(negedge clk);
        upd_valid = 1'b0;
        #1;
        chk(32'(pred_hist), 32'd1, "R9 hist after update");
        do_update(16'h0000, 2'd0, 1'b0);
        do_update(16'h0000, 2'd0, 1'b0);
        probe(16'h0030, 1'b1, 2'd0, "R9 update landed");

        // R1: reset mid-run restores initial state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        probe(16'h0030, 1'b0, 2'd0, "R1 reset again");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule